// File: doc/BRIEF.md
# Pattern Generator Dataway Command Port

This block sits between a crate dataway and a 24-bit pattern generator that plays words out of a 1024-word memory. Each dataway cycle arrives as a single-clock strobe qualified by the station select, a 5-bit function code and a 4-bit subaddress. Only subaddress 0 is decoded. The block loads and steps a memory address register, writes words into memory and reads them back through a one-word read-ahead register. It also reports a status word and a fixed module number, and holds the generator's run flag.

A read returns the word that the read-ahead register already holds. It then refills that register from the current address and steps the address. An address load also fills the read-ahead register from the new address. As a result, the first two reads after a load both return the loaded word. Address stepping can be switched off by a flag carried in the load word. The generator's run flag can be turned off immediately. It can also be armed to turn on or off at the next sequence-start or initialize event.

The generator fetches its words through a separate registered read port on the same memory.

Top module: `pgen_dataway_port`

## Requirements
- R1: Function 20 loads the address register from write-data bits 9..0 and the stepping-inhibit flag from write-data bit 15 (1 = no stepping).
- R2: Function 16 stores write-data bits 23..0 at the current address, then steps the address by one unless stepping is inhibited.
- R3: Function 0 returns the read-ahead word, refills it from the current address and then steps the address. After a function-20 load, reads return the loaded word twice and then the following words in order.
- R4: With stepping inhibited, repeated writes and reads all use the same address.
- R5: Stepping from address 0x3FF wraps to 0x000.
- R6: Function 4 returns a status word with bit 0 = generator on, bit 1 = clock overflow, and all other bits 0.
- R7: Function 6 returns the module number parameter (default 70).
- R8: Function 9 turns the generator off at once, clears the overflow flag and any armed on/off request, and pulses `clear_o` high for one cycle.
- R9: Function 26 arms a turn-on and function 24 arms a turn-off. The generator state changes only at the next `init_evt_i` or `seq_evt_i` pulse.
- R10: A pulse on `ovf_evt_i` sets the overflow flag, which stays set until function 9.
- R11: A strobe without select, with a nonzero subaddress, or with a function code outside {0,4,6,9,16,20,24,26} changes no state and leaves `accept_o` low.
- R12: `accept_o` is high for exactly the cycle after a decoded command. Read data is valid in that same cycle.
- R13: The generator read port returns the memory word at `gen_raddr_i` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | One-cycle command strobe |
| sel_i | input | 1 | Station select qualifying the strobe |
| func_i | input | 5 | Function code |
| sub_i | input | 4 | Subaddress |
| wdata_i | input | 24 | Write data |
| rdata_o | output | 24 | Read data |
| accept_o | output | 1 | Command accepted, one cycle after strobe |
| clear_o | output | 1 | One-cycle module clear pulse |
| gen_on_o | output | 1 | Generator run flag |
| init_evt_i | input | 1 | Initialize event pulse |
| seq_evt_i | input | 1 | Sequence-start event pulse |
| ovf_evt_i | input | 1 | Clock overflow pulse |
| gen_raddr_i | input | 10 | Generator read address |
| gen_rdata_o | output | 24 | Generator read data |

## Verification
The assertions check on every cycle the accept response to decoded and undecoded strobes, the immediate clear of the run flag and overflow flag, the holding of the overflow flag, the run flag's stability between events, and address wrap. The data path itself can only be shown by the bench's scenarios. These cover the doubled first read after a load, inhibited stepping, stored words coming back at the right addresses, and the delayed effect of armed on/off requests.

// File: rtl/pgen_dataway_port.sv
module pgen_dataway_port #(
  parameter int AW      = 10,
  parameter int DW      = 24,
  parameter int MODNUM  = 70,
  parameter int INH_BIT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_i,
  input  logic          sel_i,
  input  logic [4:0]    func_i,
  input  logic [3:0]    sub_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          accept_o,
  output logic          clear_o,
  output logic          gen_on_o,
  input  logic          init_evt_i,
  input  logic          seq_evt_i,
  input  logic          ovf_evt_i,
  input  logic [AW-1:0] gen_raddr_i,
  output logic [DW-1:0] gen_rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] addr_q;
  logic          inh_q;
  logic [DW-1:0] ahead_q;
  logic          ovf_q, arm_on_q, arm_off_q;

  wire go     = strobe_i & sel_i & (sub_i == 4'd0);
  wire f_rd   = go & (func_i == 5'd0);
  wire f_st   = go & (func_i == 5'd4);
  wire f_id   = go & (func_i == 5'd6);
  wire f_clr  = go & (func_i == 5'd9);
  wire f_wr   = go & (func_i == 5'd16);
  wire f_ld   = go & (func_i == 5'd20);
  wire f_off  = go & (func_i == 5'd24);
  wire f_on   = go & (func_i == 5'd26);
  wire known  = f_rd | f_st | f_id | f_clr | f_wr | f_ld | f_off | f_on;
  wire step   = (f_rd | f_wr) & ~inh_q;
  wire evt    = init_evt_i | seq_evt_i;

  wire [DW-1:0] status = {{(DW-2){1'b0}}, ovf_q, gen_on_o};

  always_ff @(posedge clk) begin
    if (f_wr) mem[addr_q] <= wdata_i;
    gen_rdata_o <= mem[gen_raddr_i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      inh_q   <= 1'b0;
      ahead_q <= '0;
    end else if (f_ld) begin
      addr_q  <= wdata_i[AW-1:0];
      inh_q   <= wdata_i[INH_BIT];
      ahead_q <= mem[wdata_i[AW-1:0]];
    end else begin
      if (f_rd) ahead_q <= mem[addr_q];
      if (step) addr_q <= addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      accept_o <= 1'b0;
      clear_o  <= 1'b0;
    end else begin
      accept_o <= known;
      clear_o  <= f_clr;
      if (f_rd)      rdata_o <= ahead_q;
      else if (f_st) rdata_o <= status;
      else if (f_id) rdata_o <= DW'(MODNUM);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q     <= 1'b0;
      gen_on_o  <= 1'b0;
      arm_on_q  <= 1'b0;
      arm_off_q <= 1'b0;
    end else if (f_clr) begin
      ovf_q     <= 1'b0;
      gen_on_o  <= 1'b0;
      arm_on_q  <= 1'b0;
      arm_off_q <= 1'b0;
    end else begin
      if (ovf_evt_i) ovf_q <= 1'b1;
      if (evt) begin
        if (arm_on_q)  gen_on_o <= 1'b1;
        if (arm_off_q) gen_on_o <= 1'b0;
        arm_on_q  <= 1'b0;
        arm_off_q <= 1'b0;
      end
      if (f_on) begin
        arm_on_q  <= 1'b1;
        arm_off_q <= 1'b0;
      end
      if (f_off) begin
        arm_off_q <= 1'b1;
        arm_on_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pgen_dataway_port_chk.sv
module pgen_dataway_port_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe_i,
  input logic          sel_i,
  input logic [4:0]    func_i,
  input logic [3:0]    sub_i,
  input logic          init_evt_i,
  input logic          seq_evt_i,
  input logic          accept_o,
  input logic          clear_o,
  input logic          gen_on_o,
  input logic          ovf_q,
  input logic          inh_q,
  input logic [AW-1:0] addr_q
);
  wire hit     = strobe_i && sel_i && sub_i == 4'd0;
  wire code_ok = func_i inside {5'd0, 5'd4, 5'd6, 5'd9, 5'd16, 5'd20, 5'd24, 5'd26};
  wire cmd_clr = hit && func_i == 5'd9;
  wire cmd_mv  = hit && (func_i == 5'd0 || func_i == 5'd16);

  assert_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hit && code_ok |=> accept_o);
  assert_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && code_ok) |=> !accept_o);
  assert_clear_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> !gen_on_o && !ovf_q && clear_o);
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !cmd_clr |=> ovf_q);
  assert_run_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !init_evt_i && !seq_evt_i && !cmd_clr |=> $stable(gen_on_o));
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_mv && !inh_q && addr_q == {AW{1'b1}} |=> addr_q == '0);
endmodule

bind pgen_dataway_port pgen_dataway_port_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .sel_i(sel_i),
  .func_i(func_i), .sub_i(sub_i), .init_evt_i(init_evt_i), .seq_evt_i(seq_evt_i),
  .accept_o(accept_o), .clear_o(clear_o), .gen_on_o(gen_on_o),
  .ovf_q(ovf_q), .inh_q(inh_q), .addr_q(addr_q)
);

// File: tb/pgen_dataway_port_tb_top.sv
module pgen_dataway_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe_i = 1'b0, sel_i = 1'b0;
  logic [4:0] func_i = '0;
  logic [3:0] sub_i = '0;
  logic [23:0] wdata_i = '0;
  logic init_evt_i = 1'b0, seq_evt_i = 1'b0, ovf_evt_i = 1'b0;
  logic [9:0] gen_raddr_i = '0;
  logic [23:0] rdata_o, gen_rdata_o;
  logic accept_o, clear_o, gen_on_o;

  always #4 clk = ~clk;

  pgen_dataway_port dut_i (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .sel_i(sel_i),
    .func_i(func_i), .sub_i(sub_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .accept_o(accept_o), .clear_o(clear_o), .gen_on_o(gen_on_o),
    .init_evt_i(init_evt_i), .seq_evt_i(seq_evt_i), .ovf_evt_i(ovf_evt_i),
    .gen_raddr_i(gen_raddr_i), .gen_rdata_o(gen_rdata_o)
  );

  typedef struct {
    logic        acc;
    logic        chk;
    logic [23:0] d;
    logic        clr;
    string       tag;
  } item_t;

  item_t sb[$];
  int vecs = 0, bad = 0;

  task automatic check(input logic [23:0] act, input logic [23:0] exp, input string tag);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic took;
    took = strobe_i;
    #2;
    if (took && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check({23'd0, accept_o}, {23'd0, it.acc}, {it.tag, " accept R12"});
      check({23'd0, clear_o}, {23'd0, it.clr}, {it.tag, " clear R8"});
      if (it.chk) check(rdata_o, it.d, it.tag);
    end
  end

  task automatic cmd(input logic s, input logic [4:0] f, input logic [3:0] a,
                     input logic [23:0] w, input logic acc, input logic chk,
                     input logic [23:0] d, input string tag);
    item_t it;
    it.acc = acc; it.chk = chk; it.d = d; it.clr = (acc && f == 5'd9); it.tag = tag;
    @(negedge clk);
    sb.push_back(it);
    strobe_i = 1'b1; sel_i = s; func_i = f; sub_i = a; wdata_i = w;
    @(negedge clk);
    strobe_i = 1'b0; sel_i = 1'b0;
  endtask

  task automatic wr(input logic [23:0] w, input string tag);
    cmd(1'b1, 5'd16, 4'd0, w, 1'b1, 1'b0, '0, tag);
  endtask
  task automatic ld(input logic [23:0] w, input string tag);
    cmd(1'b1, 5'd20, 4'd0, w, 1'b1, 1'b0, '0, tag);
  endtask
  task automatic rd(input logic [23:0] d, input string tag);
    cmd(1'b1, 5'd0, 4'd0, '0, 1'b1, 1'b1, d, tag);
  endtask
  task automatic st(input logic [23:0] d, input string tag);
    cmd(1'b1, 5'd4, 4'd0, '0, 1'b1, 1'b1, d, tag);
  endtask

  task automatic pulse_init();
    @(negedge clk); init_evt_i = 1'b1;
    @(negedge clk); init_evt_i = 1'b0;
  endtask
  task automatic pulse_seq();
    @(negedge clk); seq_evt_i = 1'b1;
    @(negedge clk); seq_evt_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({23'd0, accept_o}, 24'd0, "reset accept R12");
    check({23'd0, gen_on_o}, 24'd0, "reset run flag R9");
    check(rdata_o, 24'd0, "reset rdata R3");

    ld(24'h000010, "R1 load 0x010");
    wr(24'h111111, "R2 wr 0x010");
    wr(24'h222222, "R2 wr 0x011");
    wr(24'h333333, "R2 wr 0x012");
    ld(24'h000010, "R1 reload 0x010");
    rd(24'h111111, "R3 first read");
    rd(24'h111111, "R3 second read");
    rd(24'h222222, "R3 third read");
    rd(24'h333333, "R3 fourth read");

    ld(24'h008020, "R4 load inhibited 0x020");
    wr(24'hAAAAAA, "R4 wr");
    wr(24'hBBBBBB, "R4 wr same addr");
    ld(24'h008020, "R4 reload inhibited");
    for (int i = 0; i < 3; i++) rd(24'hBBBBBB, "R4 repeated read");

    ld(24'h0003FF, "R5 load 0x3FF");
    wr(24'h0C0C0C, "R5 wr 0x3FF");
    wr(24'h0D0D0D, "R5 wr wraps to 0x000");
    ld(24'h0003FF, "R5 reload 0x3FF");
    rd(24'h0C0C0C, "R5 read 0x3FF");
    rd(24'h0C0C0C, "R5 read 0x3FF again");
    rd(24'h0D0D0D, "R5 read after wrap");

    cmd(1'b1, 5'd6, 4'd0, '0, 1'b1, 1'b1, 24'd70, "R7 module number");

    st(24'd0, "R6 idle status");
    @(negedge clk); ovf_evt_i = 1'b1;
    @(negedge clk); ovf_evt_i = 1'b0;
    st(24'd2, "R10 overflow set");
    repeat (3) @(negedge clk);
    st(24'd2, "R10 overflow held");
    cmd(1'b1, 5'd26, 4'd0, '0, 1'b1, 1'b0, '0, "R9 arm on");
    st(24'd2, "R9 still off before event");
    pulse_init();
    st(24'd3, "R9 on after init");
    check({23'd0, gen_on_o}, 24'd1, "R9 run flag pin");
    cmd(1'b1, 5'd24, 4'd0, '0, 1'b1, 1'b0, '0, "R9 arm off");
    st(24'd3, "R9 still on before event");
    pulse_seq();
    st(24'd2, "R9 off after seq");
    cmd(1'b1, 5'd26, 4'd0, '0, 1'b1, 1'b0, '0, "R9 arm on again");
    pulse_seq();
    st(24'd3, "R6 on and overflow");
    cmd(1'b1, 5'd26, 4'd0, '0, 1'b1, 1'b0, '0, "R8 arm before clear");
    cmd(1'b1, 5'd9, 4'd0, '0, 1'b1, 1'b0, '0, "R8 clear");
    st(24'd0, "R8 status after clear");
    pulse_init();
    st(24'd0, "R8 armed request dropped");

    ld(24'h000010, "R11 load 0x010");
    cmd(1'b1, 5'd20, 4'd1, 24'h0003FF, 1'b0, 1'b0, '0, "R11 load at subaddr 1");
    cmd(1'b0, 5'd0, 4'd0, '0, 1'b0, 1'b0, '0, "R11 read unselected");
    cmd(1'b1, 5'd17, 4'd0, 24'h0003FF, 1'b0, 1'b0, '0, "R11 unknown code");
    cmd(1'b1, 5'd16, 4'd2, 24'h777777, 1'b0, 1'b0, '0, "R11 write at subaddr 2");
    rd(24'h111111, "R11 address unchanged");
    rd(24'h111111, "R11 second read");
    rd(24'h222222, "R11 third read");

    @(negedge clk); gen_raddr_i = 10'h011;
    @(negedge clk);
    check(gen_rdata_o, 24'h222222, "R13 gen port 0x011");
    gen_raddr_i = 10'h000;
    @(negedge clk);
    check(gen_rdata_o, 24'h0D0D0D, "R13 gen port 0x000");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R12: actual %0d pending responses expected 0", sb.size());
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule